// File: doc/BRIEF.md
# Serial Keyboard Command Responder

This block plays the device end of a serial keyboard link. The host sends it command bytes. For the commands it knows, it answers with fixed two-byte replies. It also takes key events from a scanner and places the resulting scancodes in the same small circular output queue. The host drains that queue one byte at a time. A byte is available whenever the queue holds at least one entry.

Lock keys such as caps or num lock are filtered so that each one behaves as a toggle. Every lock key keeps a two-bit mode:

- A press flips bit 0 of the mode.
- A release flips bit 1 of the mode.
- A press that leaves the mode at 2 is dropped.
- A release that leaves the mode at 3 is dropped.

As a result, only the first press and the second release of a lock key reach the host.

All three byte paths use a valid/ready handshake, and a transfer happens on a rising clock edge where both are high.

- **Output path:** the head byte stays on `out_data` until it is taken.
- **Command path:** it stalls for the one cycle in which the second reply byte is written.
- **Key path:** it stalls whenever a command is offered or a reply byte is still pending.

The queue itself never pushes back. A byte that finds the queue full is lost.

Top module: `kbd_responder`

## Requirements
- R1: An accepted command byte 0x01 writes 0xFF and then 0x04 into the queue, in that order, on two consecutive cycles.
- R2: An accepted command byte 0x07 writes 0xFE and then 0x21 into the queue, in that order, on two consecutive cycles.
- R3: An accepted command byte 0x0E writes nothing. The next accepted command byte, whatever its value, is swallowed: it writes nothing and starts no command.
- R4: Any other command byte (not 0x01, 0x07 or 0x0E, and not swallowed) writes nothing into the queue.
- R5: The queue is first-in first-out. `out_valid` is high exactly when it holds at least one byte. The head is removed on a cycle with `out_valid` and `out_ready` both high, and it stays stable while it is not taken.
- R6: A write that arrives while the queue already holds DEPTH bytes (counted at the start of that cycle) is discarded. The read and write positions wrap at DEPTH, so the queue keeps working after any number of passes.
- R7: For a key whose `key_lock_sel` is a value from 1 to NUM_LOCKS, the scancode passes only if the lock-key mode rules stated above allow it. Each lock key keeps its own mode.
- R8: A key with `key_lock_sel` = 0 or above NUM_LOCKS always writes its `key_code` into the queue.
- R9: While the queue is empty, `out_data` shows the byte most recently taken (0 after reset), and `out_ready` has no effect.
- R10: Reset empties the queue, clears the pending LED-data flag and every lock-key mode, and sets `out_data` to 0.
- R11: `cmd_ready` is low in the cycle after a two-byte reply command is accepted. `key_ready` is low whenever `cmd_valid` is high or a second reply byte is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Host command byte offered |
| cmd_ready | output | 1 | Command byte can be taken |
| cmd_data | input | 8 | Host command byte |
| key_valid | input | 1 | Key event offered |
| key_ready | output | 1 | Key event can be taken |
| key_code | input | 8 | Scancode to report |
| key_lock_sel | input | $clog2(NUM_LOCKS+1) | 0 = ordinary key, 1..NUM_LOCKS = lock key index |
| key_release | input | 1 | 1 = release event, 0 = press |
| out_valid | output | 1 | Queue holds at least one byte |
| out_ready | input | 1 | Host takes the head byte |
| out_data | output | 8 | Head byte, or last taken byte when empty |

## Verification
The bench builds the block with DEPTH = 4 and NUM_LOCKS = 2.

- **Small queue:** with only four entries, the queue fills within a few writes, so dropped key bytes can be checked. So can a reply whose second byte is lost on a full queue, and pointer wrap across more than one pass.
- **Two lock keys:** these show that the lock modes are independent of each other.
- **Selector width:** the two-bit selector can also take the value 3, which lies beyond the lock range and must act as an ordinary key.

// File: rtl/kbd_resp_pkg.sv
package kbd_resp_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // host command opcodes
  localparam byte_t OP_RESET  = 8'h01;
  localparam byte_t OP_LAYOUT = 8'h07;
  localparam byte_t OP_LEDS   = 8'h0E;

  // reply bytes
  localparam byte_t RSP_RESET_HDR  = 8'hFF;
  localparam byte_t RSP_KBD_TYPE   = 8'h04;
  localparam byte_t RSP_LAYOUT_HDR = 8'hFE;
  localparam byte_t RSP_LAYOUT_ID  = 8'h21;

  // lock-key mode: bit 0 = press parity, bit 1 = release parity
  typedef logic [1:0] lock_mode_t;
  localparam lock_mode_t LOCK_PRESS_BIT   = 2'b01;
  localparam lock_mode_t LOCK_RELEASE_BIT = 2'b10;
  localparam lock_mode_t LOCK_DROP_PRESS  = 2'b10;
  localparam lock_mode_t LOCK_DROP_REL    = 2'b11;
endpackage

// File: rtl/kbd_byte_fifo.sv
module kbd_byte_fifo
  import kbd_resp_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  byte_t                      push_data,
  input  logic                       pop_ready,
  output logic                       head_valid,
  output byte_t                      head_data,
  output logic [$clog2(DEPTH+1)-1:0] fill
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  byte_t         mem [DEPTH];
  logic [AW-1:0] wptr;
  logic [AW-1:0] rptr;
  byte_t         last_taken;
  logic          full;
  logic          do_wr;
  logic          do_rd;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + AW'(1);
  endfunction

  assign full       = (fill == CW'(DEPTH));
  assign head_valid = (fill != '0);
  assign do_wr      = push && !full;
  assign do_rd      = head_valid && pop_ready;
  assign head_data  = head_valid ? mem[rptr] : last_taken;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr       <= '0;
      rptr       <= '0;
      fill       <= '0;
      last_taken <= '0;
    end else begin
      if (do_wr) wptr <= step(wptr);
      if (do_rd) begin
        rptr       <= step(rptr);
        last_taken <= mem[rptr];
      end
      case ({do_wr, do_rd})
        2'b10:   fill <= fill + CW'(1);
        2'b01:   fill <= fill - CW'(1);
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/kbd_cmd_decoder.sv
module kbd_cmd_decoder
  import kbd_resp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cmd_valid,
  output logic  cmd_ready,
  input  byte_t cmd_data,
  output logic  rsp_wr,
  output byte_t rsp_byte,
  output logic  rsp_busy,
  output logic  leds_pending
);
  logic  tail_valid;
  byte_t tail_byte;
  logic  take;
  logic  act;

  assign cmd_ready = !tail_valid;
  assign rsp_busy  = tail_valid;
  assign take      = cmd_valid && cmd_ready;
  assign act       = take && !leds_pending;

  always_comb begin
    rsp_wr   = 1'b0;
    rsp_byte = '0;
    if (tail_valid) begin
      rsp_wr   = 1'b1;
      rsp_byte = tail_byte;
    end else if (act) begin
      case (cmd_data)
        OP_RESET: begin
          rsp_wr   = 1'b1;
          rsp_byte = RSP_RESET_HDR;
        end
        OP_LAYOUT: begin
          rsp_wr   = 1'b1;
          rsp_byte = RSP_LAYOUT_HDR;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tail_valid   <= 1'b0;
      tail_byte    <= '0;
      leds_pending <= 1'b0;
    end else begin
      if (tail_valid) tail_valid <= 1'b0;
      if (take && leds_pending) begin
        leds_pending <= 1'b0;
      end else if (act) begin
        case (cmd_data)
          OP_RESET: begin
            tail_valid <= 1'b1;
            tail_byte  <= RSP_KBD_TYPE;
          end
          OP_LAYOUT: begin
            tail_valid <= 1'b1;
            tail_byte  <= RSP_LAYOUT_ID;
          end
          OP_LEDS: leds_pending <= 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/kbd_lock_filter.sv
module kbd_lock_filter
  import kbd_resp_pkg::*;
#(
  parameter int NUM_LOCKS = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ev,
  input  logic [$clog2(NUM_LOCKS+1)-1:0] sel,
  input  logic                           release_ev,
  output logic                           pass
);
  localparam int SW = $clog2(NUM_LOCKS + 1);

  logic [NUM_LOCKS-1:0] drop;

  for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lock
    lock_mode_t mode;
    lock_mode_t nxt;
    logic       hit;

    assign hit = ev && (sel == SW'(g + 1));
    assign nxt = mode ^ (release_ev ? LOCK_RELEASE_BIT : LOCK_PRESS_BIT);
    assign drop[g] = hit &&
                     (release_ev ? (nxt == LOCK_DROP_REL) : (nxt == LOCK_DROP_PRESS));

    always_ff @(posedge clk) begin
      if (!rst_n)   mode <= '0;
      else if (hit) mode <= nxt;
    end
  end

  assign pass = ev && !(|drop);
endmodule

// File: rtl/kbd_responder.sv
module kbd_responder
  import kbd_resp_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int NUM_LOCKS = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cmd_valid,
  output logic                           cmd_ready,
  input  logic [7:0]                     cmd_data,
  input  logic                           key_valid,
  output logic                           key_ready,
  input  logic [7:0]                     key_code,
  input  logic [$clog2(NUM_LOCKS+1)-1:0] key_lock_sel,
  input  logic                           key_release,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [7:0]                     out_data
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          dec_wr;
  byte_t         dec_byte;
  logic          dec_busy;
  logic          led_skip;
  logic          key_take;
  logic          key_pass;
  logic          fifo_push;
  byte_t         fifo_wdata;
  logic [CW-1:0] fifo_count;

  kbd_cmd_decoder u_dec (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_data     (cmd_data),
    .rsp_wr       (dec_wr),
    .rsp_byte     (dec_byte),
    .rsp_busy     (dec_busy),
    .leds_pending (led_skip)
  );

  // key events yield to any command traffic
  assign key_ready = !dec_busy && !cmd_valid;
  assign key_take  = key_valid && key_ready;

  kbd_lock_filter #(.NUM_LOCKS(NUM_LOCKS)) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev         (key_take),
    .sel        (key_lock_sel),
    .release_ev (key_release),
    .pass       (key_pass)
  );

  assign fifo_push  = dec_wr || key_pass;
  assign fifo_wdata = dec_wr ? dec_byte : key_code;

  kbd_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (fifo_push),
    .push_data  (fifo_wdata),
    .pop_ready  (out_ready),
    .head_valid (out_valid),
    .head_data  (out_data),
    .fill       (fifo_count)
  );
endmodule

// File: rtl/kbd_responder_chk.sv
module kbd_responder_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [7:0]    cmd_data,
  input logic          key_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [7:0]    out_data,
  input logic          dec_busy,
  input logic          led_skip,
  input logic          fifo_push,
  input logic [CW-1:0] fifo_count
);
  a_r5_head_held: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r5_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !fifo_push) |=> (fifo_count == $past(fifo_count) - CW'(1)));

  a_r9_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |=> (out_valid || $stable(out_data)));

  a_r6_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));

  a_r6_full_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count == CW'(DEPTH) && !out_ready) |=> (fifo_count == CW'(DEPTH)));

  a_r11_key_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid || dec_busy) |-> !key_ready);

  a_r11_second_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !led_skip && (cmd_data == 8'h01 || cmd_data == 8'h07))
      |=> (!cmd_ready && fifo_push));

  a_r3_swallow: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && led_skip) |=> (!dec_busy && !led_skip));
endmodule

bind kbd_responder kbd_responder_chk #(.DEPTH(DEPTH), .CW($clog2(DEPTH+1))) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_data   (cmd_data),
  .key_ready  (key_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .dec_busy   (dec_busy),
  .led_skip   (led_skip),
  .fifo_push  (fifo_push),
  .fifo_count (fifo_count)
);

// File: tb/kbd_responder_tb.sv
`timescale 1ns/1ps
module kbd_responder_tb;
  localparam int DEPTH = 4;
  localparam int NL    = 2;
  localparam int SW    = $clog2(NL + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [7:0]    cmd_data = '0;
  logic          key_valid = 1'b0;
  logic          key_ready;
  logic [7:0]    key_code = '0;
  logic [SW-1:0] key_lock_sel = '0;
  logic          key_release = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [7:0]    out_data;

  always #10 clk = ~clk;

  kbd_responder #(.DEPTH(DEPTH), .NUM_LOCKS(NL)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .key_valid(key_valid), .key_ready(key_ready), .key_code(key_code),
    .key_lock_sel(key_lock_sel), .key_release(key_release),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int         checks = 0;
  int         bad = 0;
  logic [7:0] sb[$];
  logic [7:0] last_seen = '0;
  logic       m_skip = 1'b0;
  logic [1:0] m_lock [NL+1];
  string      cur_tag = "R5";

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic expect_byte(input logic [7:0] b);
    if (sb.size() < DEPTH) sb.push_back(b);
  endtask

  // monitor: compare every delivered byte against the scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (sb.size() == 0) begin
        check(1'b0, {cur_tag, " unexpected byte"}, out_data, 0);
      end else begin
        check(out_data == sb[0], cur_tag, out_data, sb[0]);
        void'(sb.pop_front());
      end
      last_seen = out_data;
    end
  end

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; cmd_valid = 1'b0; key_valid = 1'b0; out_ready = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    sb.delete();
    m_skip = 1'b0;
    last_seen = '0;
    for (int i = 0; i <= NL; i++) m_lock[i] = '0;
  endtask

  task automatic send_cmd(input logic [7:0] b);
    logic acc;
    logic two;
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_data = b;
    do begin
      @(negedge clk); acc = cmd_ready;
      @(posedge clk);
    end while (!acc);
    two = 1'b0;
    if (m_skip) m_skip = 1'b0;
    else if (b == 8'h01) begin expect_byte(8'hFF); expect_byte(8'h04); two = 1'b1; end
    else if (b == 8'h07) begin expect_byte(8'hFE); expect_byte(8'h21); two = 1'b1; end
    else if (b == 8'h0E) m_skip = 1'b1;
    #1 cmd_valid = 1'b0;
    if (two) begin
      @(negedge clk);
      check(cmd_ready == 1'b0, "R11 cmd_ready during second byte", cmd_ready, 0);
    end
  endtask

  task automatic send_key(input logic [7:0] c, input int sel, input logic rel);
    logic acc;
    logic [1:0] n;
    @(posedge clk); #1;
    key_valid = 1'b1; key_code = c; key_lock_sel = SW'(sel); key_release = rel;
    do begin
      @(negedge clk); acc = key_ready;
      @(posedge clk);
    end while (!acc);
    if (sel >= 1 && sel <= NL) begin
      n = m_lock[sel] ^ (rel ? 2'b10 : 2'b01);
      m_lock[sel] = n;
      if (!(rel ? (n == 2'b11) : (n == 2'b10))) expect_byte(c);
    end else begin
      expect_byte(c);
    end
    #1 key_valid = 1'b0;
  endtask

  task automatic drain(input string tag);
    cur_tag = tag;
    @(posedge clk); #1 out_ready = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!out_valid) break;
    end
    @(posedge clk); #1 out_ready = 1'b0;
    check(sb.size() == 0, {tag, " bytes missing"}, sb.size(), 0);
  endtask

  initial begin
    for (int i = 0; i <= NL; i++) m_lock[i] = '0;
    do_reset();
    @(negedge clk);
    // R10 reset state
    check(out_valid == 1'b0, "R10 out_valid after reset", out_valid, 0);
    check(out_data == 8'h00, "R10 out_data after reset", out_data, 0);
    check(cmd_ready && key_ready, "R11 ready after reset", {cmd_ready, key_ready}, 3);

    send_cmd(8'h01);                    // R1
    drain("R1");
    send_cmd(8'h07);                    // R2
    drain("R2");

    send_cmd(8'h33);                    // R4 unknown commands
    send_cmd(8'h00);
    @(negedge clk);
    check(out_valid == 1'b0, "R4 no reply to unknown", out_valid, 0);
    drain("R4");

    send_cmd(8'h0E);                    // R3: next byte swallowed
    send_cmd(8'h01);
    @(negedge clk);
    check(out_valid == 1'b0, "R3 LED data swallowed", out_valid, 0);
    send_cmd(8'h07);
    drain("R3");

    send_key(8'h1C, 0, 1'b0);           // R8 ordinary key
    send_key(8'h2A, 3, 1'b0);           // R8 selector beyond lock range
    drain("R8");

    send_key(8'h77, 1, 1'b0);           // R7 lock 1 press: passes
    send_key(8'hF7, 1, 1'b1);           // release: dropped
    send_key(8'h77, 1, 1'b0);           // press: dropped
    check(sb.size() == 1, "R7 model count", sb.size(), 1);
    send_key(8'hF7, 1, 1'b1);           // release: passes
    send_key(8'h62, 2, 1'b0);           // lock 2 independent press: passes
    drain("R7");

    // R11 key path blocked while a command is offered
    @(posedge clk); #1 cmd_valid = 1'b1; cmd_data = 8'h55;
    @(negedge clk);
    check(key_ready == 1'b0, "R11 key_ready with cmd_valid", key_ready, 0);
    @(posedge clk); #1 cmd_valid = 1'b0;

    // R6 full queue drops, then wrap
    for (int k = 0; k < 6; k++) send_key(8'hA0 + 8'(k), 0, 1'b0);
    check(sb.size() == DEPTH, "R6 model holds DEPTH", sb.size(), DEPTH);
    drain("R6");
    send_key(8'hB1, 0, 1'b0);
    send_key(8'hB2, 0, 1'b0);
    drain("R6 wrap");
    for (int k = 0; k < 3; k++) send_key(8'hC0 + 8'(k), 0, 1'b0);
    send_cmd(8'h01);                    // 0xFF fits, 0x04 lost
    drain("R6 reply cut");

    // R9 empty queue holds last byte, out_ready has no effect
    @(negedge clk);
    check(out_data == last_seen, "R9 empty shows last byte", out_data, last_seen);
    @(posedge clk); #1 out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid && out_data == last_seen, "R9 ready on empty", out_data, last_seen);
    @(posedge clk); #1 out_ready = 1'b0;

    // R10 reset clears queue, LED flag and lock modes
    send_key(8'h11, 0, 1'b0);
    send_cmd(8'h0E);
    send_key(8'h77, 1, 1'b0);
    @(negedge clk);
    check(out_valid == 1'b1, "R10 queue filled before reset", out_valid, 1);
    do_reset();
    @(negedge clk);
    check(out_valid == 1'b0 && out_data == 8'h00, "R10 queue cleared", out_data, 0);
    send_cmd(8'h01);
    send_key(8'h77, 1, 1'b0);
    check(sb.size() == 3, "R10 model after reset", sb.size(), 3);
    drain("R10");

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule